// File: doc/BRIEF.md
# Multi-Channel Timer Register Bank

This block is the software-facing register front end for a group of timer channels. A single 32-bit request port carries word accesses at byte offsets. The block decodes each access to one of three targets: a per-channel register (count status, reload value, first match, second match), the shared control word, or a second control word. The second control word is stored and can be read back but drives nothing. The per-channel counters sit behind this block. They take their settings from its outputs and return their live count on `ch_count`. A status write to a running channel reaches its counter as a one-cycle load strobe.

The address map leaves room for the control words between the low channels and the high channels. Channels 0 to 2 sit in 16-byte slots 0 to 2. Slot 3 holds the control words. Channels 3 and up sit one slot higher than their index. Control writes are applied per channel in a fixed order over three clock cycles. Enables that drop are applied first. The clock-select, overflow-interrupt and pulse settings follow. Enables that rise are applied last. A channel therefore never runs with a mix of old and new settings. The request port stalls until the sequence has finished.

Top module: `tmr_reg_bank`

## Requirements
- R1: After reset, `req_ready` is 1, every channel output is 0, and the control word, the second control word and every reload and match register read as 0.
- R2: A channel's registers sit at offset 16×slot + 4×sel, with sel 0 status, 1 reload, 2 first match and 3 second match. Channel c uses slot c for c < 3 and slot c+1 for c ≥ 3. A write updates only the addressed register, which drives `ch_reload`, `ch_match_a` or `ch_match_b` and reads back unchanged.
- R3: A read of a channel's status register returns that channel's 32-bit slice of `ch_count`.
- R4: A status write to an enabled channel raises that channel's `ch_load` bit for exactly one cycle, in the cycle after acceptance, with the data on `ch_load_value`. A status write to a disabled channel raises no `ch_load` bit.
- R5: The control word (offset 0x30) gives channel c bits 4c+0 enable, 4c+1 external clock select, 4c+2 overflow interrupt enable and 4c+3 pulse enable. It reads back as written once its sequence has completed.
- R6: A control write clears the falling enables at the acceptance edge, applies the other three bits of every channel one cycle later, and sets the rising enables two cycles after acceptance. `req_ready` stays 0 for the two cycles between acceptance and the end of the sequence.
- R7: `ch_pulse` follows the stored pulse bit only for channels with index ≥ PULSE_FIRST (default 4) and stays 0 for the others. A control write that changes the pulse bit of a channel below PULSE_FIRST raises `err`, and the bit is still stored and read back.
- R8: The second control word at offset 0x34 stores all 32 bits and reads back, and writing it changes no channel output.
- R9: Offsets 0x38 and 0x3C and every offset at or beyond 16×(N_CH+1) are illegal. An illegal read returns 0, an illegal write changes nothing, and both raise `err` for one cycle, in the cycle after acceptance.
- R10: Every accepted read raises `rd_valid` for one cycle, in the cycle after acceptance, with the data on `rd_data`. An access is accepted on a clock edge where `req_valid` and `req_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block can accept an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 12 | Byte offset, word aligned |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_data | output | 32 | Read data |
| err | output | 1 | Illegal access or forbidden pulse change, one cycle |
| ch_count | input | 32×N_CH | Live count of each channel |
| ch_enable | output | N_CH | Channel run enable |
| ch_ext_clk | output | N_CH | External clock select |
| ch_ovf_irq | output | N_CH | Overflow interrupt enable |
| ch_pulse | output | N_CH | Pulse mode, capable channels only |
| ch_reload | output | 32×N_CH | Reload values |
| ch_match_a | output | 32×N_CH | First match values |
| ch_match_b | output | 32×N_CH | Second match values |
| ch_load | output | N_CH | Status-write load strobe |
| ch_load_value | output | 32 | Value for the load strobe |

## Verification
The bench builds the block with its defaults: eight channels, pulse capability from index 4, and 32-bit data. These values put channels on both sides of the address gap, and they make the top slot at 0x80 and the first out-of-map slot at 0x90 reachable. They also place channels on both sides of the pulse-capability boundary within the same control word. A single control write that disables one channel and enables another while changing both channels' settings exposes each of the three sequencing steps at the ports.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;

  // access targets produced by the offset decoder
  typedef enum logic [1:0] {
    T_CHAN  = 2'd0,
    T_CTRL  = 2'd1,
    T_CTRL2 = 2'd2,
    T_BAD   = 2'd3
  } tgt_e;

  // per-channel register selector, taken from offset[3:2]
  typedef enum logic [1:0] {
    R_STAT    = 2'd0,
    R_RELOAD  = 2'd1,
    R_MATCH_A = 2'd2,
    R_MATCH_B = 2'd3
  } reg_e;

  localparam int OFS_W    = 12;
  localparam int CTL_BITS = 4;
  localparam int B_EN     = 0;
  localparam int B_EXT    = 1;
  localparam int B_OVF    = 2;
  localparam int B_PULSE  = 3;

  // 16-byte slot that holds the two control words
  localparam logic [7:0] CTRL_SLOT = 8'd3;

  // bit position of one control field of one channel
  function automatic int ctl_pos(input int ch, input int field);
    return ch * CTL_BITS + field;
  endfunction

endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
  import tmr_bank_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic [OFS_W-1:0]          offset_i,
  output tgt_e                      tgt_o,
  output logic [$clog2(N_CH)-1:0]   ch_o,
  output reg_e                      rsel_o
);
  localparam int CH_W = $clog2(N_CH);
  localparam logic [7:0] LAST_SLOT = 8'(N_CH);

  logic [7:0] slot;
  logic       unused_lsb;

  assign slot       = offset_i[OFS_W-1:4];
  assign unused_lsb = ^offset_i[1:0];
  assign rsel_o     = reg_e'(offset_i[3:2]);

  // slots below the control slot map straight to a channel, slots above it
  // are shifted down by one to skip the gap
  function automatic logic [CH_W-1:0] slot_to_ch(input logic [7:0] s);
    if (s < CTRL_SLOT) return CH_W'(s);
    return CH_W'(s - 8'd1);
  endfunction

  always_comb begin
    ch_o  = slot_to_ch(slot);
    tgt_o = T_BAD;
    if (slot < CTRL_SLOT) begin
      tgt_o = T_CHAN;
    end else if (slot == CTRL_SLOT) begin
      case (offset_i[3:2])
        2'd0:    tgt_o = T_CTRL;
        2'd1:    tgt_o = T_CTRL2;
        default: tgt_o = T_BAD;
      endcase
    end else if (slot <= LAST_SLOT) begin
      tgt_o = T_CHAN;
    end
  end

endmodule

// File: rtl/tmr_ctrl_seq.sv
module tmr_ctrl_seq
  import tmr_bank_pkg::*;
#(
  parameter int N_CH        = 8,
  parameter int PULSE_FIRST = 4,
  parameter int DW          = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [DW-1:0]   word_i,
  output logic            busy_o,
  output logic            pulse_err_o,
  output logic [DW-1:0]   word_o,
  output logic [N_CH-1:0] en_o,
  output logic [N_CH-1:0] ext_o,
  output logic [N_CH-1:0] ovf_o,
  output logic [N_CH-1:0] pulse_o
);
  localparam int CW = CTL_BITS * N_CH;

  typedef enum logic [1:0] {PH_IDLE, PH_CFG, PH_ENA} ph_e;

  ph_e             ph;
  logic [CW-1:0]   pend_q;
  logic [N_CH-1:0] en_q, ext_q, ovf_q, pls_q;
  logic [N_CH-1:0] new_en, new_pls, low_mask;
  logic [N_CH-1:0] pend_en, pend_ext, pend_ovf, pend_pls;

  for (genvar i = 0; i < N_CH; i++) begin : g_fld
    assign new_en[i]   = word_i[ctl_pos(i, B_EN)];
    assign new_pls[i]  = word_i[ctl_pos(i, B_PULSE)];
    assign pend_en[i]  = pend_q[ctl_pos(i, B_EN)];
    assign pend_ext[i] = pend_q[ctl_pos(i, B_EXT)];
    assign pend_ovf[i] = pend_q[ctl_pos(i, B_OVF)];
    assign pend_pls[i] = pend_q[ctl_pos(i, B_PULSE)];
    assign word_o[i*CTL_BITS +: CTL_BITS] = {pls_q[i], ovf_q[i], ext_q[i], en_q[i]};
    if (i >= PULSE_FIRST) begin : g_pcap
      assign low_mask[i] = 1'b0;
      assign pulse_o[i]  = pls_q[i];
    end else begin : g_pnone
      assign low_mask[i] = 1'b1;
      assign pulse_o[i]  = 1'b0;
    end
  end

  if (CW < DW) begin : g_pad
    assign word_o[DW-1:CW] = '0;
  end

  assign busy_o      = (ph != PH_IDLE);
  assign pulse_err_o = start_i && |((new_pls ^ pls_q) & low_mask);
  assign en_o        = en_q;
  assign ext_o       = ext_q;
  assign ovf_o       = ovf_q;

  // step 1 at acceptance: drop enables; step 2: settings; step 3: raise enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      pend_q <= '0;
      en_q   <= '0;
      ext_q  <= '0;
      ovf_q  <= '0;
      pls_q  <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (start_i) begin
          en_q   <= en_q & new_en;
          pend_q <= word_i[CW-1:0];
          ph     <= PH_CFG;
        end
        PH_CFG: begin
          ext_q <= pend_ext;
          ovf_q <= pend_ovf;
          pls_q <= pend_pls;
          ph    <= PH_ENA;
        end
        PH_ENA: begin
          en_q <= pend_en;
          ph   <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R6: an enable may fall only at the acceptance edge
  a_r6_fall_first: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(en_q) & ~en_q)) |-> $past(start_i));
  // R6: an enable may rise only when leaving the last step
  a_r6_rise_last: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~$past(en_q) & en_q)) |-> $past(ph == PH_ENA));
  // R6: settings change only in the middle step
  a_r6_cfg_middle: assert property (@(posedge clk) disable iff (!rst_n)
    ({ext_q, ovf_q, pls_q} != $past({ext_q, ovf_q, pls_q})) |-> $past(ph == PH_CFG));
  // R6: the sequence keeps the block busy for exactly two cycles
  a_r6_busy_two: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o ##1 busy_o ##1 !busy_o);

endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_bank_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int DW   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_i,
  input  logic [$clog2(N_CH)-1:0] ch_i,
  input  reg_e                    rsel_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [N_CH-1:0]         en_i,
  output logic [N_CH*DW-1:0]      reload_o,
  output logic [N_CH*DW-1:0]      match_a_o,
  output logic [N_CH*DW-1:0]      match_b_o,
  output logic [N_CH-1:0]         load_o,
  output logic [DW-1:0]           load_val_o
);
  localparam int CH_W = $clog2(N_CH);

  logic stat_wr;
  assign stat_wr = wr_i && (rsel_i == R_STAT);

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic          hit, ld_q;
    logic [DW-1:0] rl_q, ma_q, mb_q;

    assign hit = wr_i && (ch_i == CH_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rl_q <= '0;
        ma_q <= '0;
        mb_q <= '0;
        ld_q <= 1'b0;
      end else begin
        if (hit && rsel_i == R_RELOAD)  rl_q <= wdata_i;
        if (hit && rsel_i == R_MATCH_A) ma_q <= wdata_i;
        if (hit && rsel_i == R_MATCH_B) mb_q <= wdata_i;
        ld_q <= hit && (rsel_i == R_STAT) && en_i[i];
      end
    end

    assign reload_o[i*DW +: DW]  = rl_q;
    assign match_a_o[i*DW +: DW] = ma_q;
    assign match_b_o[i*DW +: DW] = mb_q;
    assign load_o[i]             = ld_q;

    // R4: a load strobe only reaches a channel that was enabled
    a_r4_load_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      ld_q |-> $past(en_i[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       load_val_o <= '0;
    else if (stat_wr) load_val_o <= wdata_i;
  end

  // R4: every strobe follows an accepted status write
  a_r4_load_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|load_o) |-> $past(stat_wr));

endmodule

// File: rtl/tmr_reg_bank.sv
module tmr_reg_bank
  import tmr_bank_pkg::*;
#(
  parameter int N_CH        = 8,
  parameter int PULSE_FIRST = 4,
  parameter int DW          = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [OFS_W-1:0]     req_offset,
  input  logic [DW-1:0]        req_wdata,
  output logic                 rd_valid,
  output logic [DW-1:0]        rd_data,
  output logic                 err,
  input  logic [N_CH*DW-1:0]   ch_count,
  output logic [N_CH-1:0]      ch_enable,
  output logic [N_CH-1:0]      ch_ext_clk,
  output logic [N_CH-1:0]      ch_ovf_irq,
  output logic [N_CH-1:0]      ch_pulse,
  output logic [N_CH*DW-1:0]   ch_reload,
  output logic [N_CH*DW-1:0]   ch_match_a,
  output logic [N_CH*DW-1:0]   ch_match_b,
  output logic [N_CH-1:0]      ch_load,
  output logic [DW-1:0]        ch_load_value
);
  localparam int CH_W = $clog2(N_CH);

  tgt_e            tgt;
  reg_e            rsel;
  logic [CH_W-1:0] ch;
  logic            accept, busy, pulse_err, chan_wr, ctrl_start;
  logic [DW-1:0]   ctrl_word, ctrl2_q, rd_mux;

  assign req_ready  = !busy;
  assign accept     = req_valid && req_ready;
  assign chan_wr    = accept && req_write && (tgt == T_CHAN);
  assign ctrl_start = accept && req_write && (tgt == T_CTRL);

  tmr_addr_dec #(.N_CH(N_CH)) u_dec (
    .offset_i (req_offset),
    .tgt_o    (tgt),
    .ch_o     (ch),
    .rsel_o   (rsel)
  );

  tmr_ctrl_seq #(.N_CH(N_CH), .PULSE_FIRST(PULSE_FIRST), .DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (ctrl_start),
    .word_i      (req_wdata),
    .busy_o      (busy),
    .pulse_err_o (pulse_err),
    .word_o      (ctrl_word),
    .en_o        (ch_enable),
    .ext_o       (ch_ext_clk),
    .ovf_o       (ch_ovf_irq),
    .pulse_o     (ch_pulse)
  );

  tmr_chan_regs #(.N_CH(N_CH), .DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (chan_wr),
    .ch_i       (ch),
    .rsel_i     (rsel),
    .wdata_i    (req_wdata),
    .en_i       (ch_enable),
    .reload_o   (ch_reload),
    .match_a_o  (ch_match_a),
    .match_b_o  (ch_match_b),
    .load_o     (ch_load),
    .load_val_o (ch_load_value)
  );

  always_comb begin
    rd_mux = '0;
    unique case (tgt)
      T_CHAN: begin
        unique case (rsel)
          R_STAT:    rd_mux = ch_count[ch*DW +: DW];
          R_RELOAD:  rd_mux = ch_reload[ch*DW +: DW];
          R_MATCH_A: rd_mux = ch_match_a[ch*DW +: DW];
          R_MATCH_B: rd_mux = ch_match_b[ch*DW +: DW];
          default:   rd_mux = '0;
        endcase
      end
      T_CTRL:  rd_mux = ctrl_word;
      T_CTRL2: rd_mux = ctrl2_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl2_q  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      err      <= 1'b0;
    end else begin
      if (accept && req_write && tgt == T_CTRL2) ctrl2_q <= req_wdata;
      rd_valid <= accept && !req_write;
      if (accept && !req_write) rd_data <= rd_mux;
      err <= accept && ((tgt == T_BAD) || pulse_err);
    end
  end

  // R9: an illegal access is flagged in the next cycle
  a_r9_bad_err: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && tgt == T_BAD) |=> err);
  // R9: an illegal read returns zero
  a_r9_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && tgt == T_BAD) |=> (rd_data == '0));
  // R10: every accepted read is answered one cycle later
  a_r10_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write) |=> rd_valid);
  // R8: the second control word leaves channel enables alone
  a_r8_ctrl2_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && tgt == T_CTRL2) |=> $stable(ch_enable));

endmodule

// File: tb/tmr_reg_bank_tb_top.sv
`timescale 1ns/1ps
module tmr_reg_bank_tb_top;
  localparam int N  = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n, req_valid, req_ready, req_write, rd_valid, err;
  logic [11:0]     req_offset;
  logic [DW-1:0]   req_wdata, rd_data, ch_load_value;
  logic [N*DW-1:0] ch_count, ch_reload, ch_match_a, ch_match_b;
  logic [N-1:0]    ch_enable, ch_ext_clk, ch_ovf_irq, ch_pulse, ch_load;

  tmr_reg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_offset(req_offset), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .err(err), .ch_count(ch_count),
    .ch_enable(ch_enable), .ch_ext_clk(ch_ext_clk), .ch_ovf_irq(ch_ovf_irq),
    .ch_pulse(ch_pulse), .ch_reload(ch_reload), .ch_match_a(ch_match_a),
    .ch_match_b(ch_match_b), .ch_load(ch_load), .ch_load_value(ch_load_value)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic          last_err, last_rv;
  logic [DW-1:0] last_rd;

  function automatic logic [31:0] cnt_of(input int c);
    return 32'hC0DE_0000 + 32'(c) * 32'h0000_0101;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [11:0] off, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_offset = off; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    last_err = err; last_rv = rd_valid; last_rd = rd_data;
  endtask

  task automatic rd_expect(input string req, input logic [11:0] off,
                           input logic [31:0] exp, input logic exp_err);
    bus(1'b0, off, 32'h0);
    chk(req, last_rv, 1'b1);
    chk(req, last_rd, exp);
    chk(req, last_err, exp_err);
  endtask

  task automatic t_reset;
    chk("R1 ready", req_ready, 1'b1);
    chk("R1 outputs", {ch_enable, ch_ext_clk, ch_ovf_irq, ch_pulse}, 32'h0);
    chk("R1 regs", 32'(|{ch_reload, ch_match_a, ch_match_b}), 32'h0);
    rd_expect("R1 ctrl", 12'h030, 32'h0, 1'b0);
    rd_expect("R1 ctrl2", 12'h034, 32'h0, 1'b0);
    rd_expect("R1 reload", 12'h084, 32'h0, 1'b0);
  endtask

  task automatic t_chan_map;
    bus(1'b1, 12'h004, 32'hA1A1_0001);
    chk("R2 ch0 reload", ch_reload[0*DW +: DW], 32'hA1A1_0001);
    bus(1'b1, 12'h028, 32'hA2A2_0002);
    chk("R2 ch2 match a", ch_match_a[2*DW +: DW], 32'hA2A2_0002);
    bus(1'b1, 12'h04C, 32'hA3A3_0003);
    chk("R2 ch3 match b", ch_match_b[3*DW +: DW], 32'hA3A3_0003);
    bus(1'b1, 12'h084, 32'hA4A4_0004);
    chk("R2 ch7 reload", ch_reload[7*DW +: DW], 32'hA4A4_0004);
    chk("R2 ch1 untouched", ch_reload[1*DW +: DW], 32'h0);
    rd_expect("R2 rb ch0", 12'h004, 32'hA1A1_0001, 1'b0);
    rd_expect("R2 rb ch3", 12'h04C, 32'hA3A3_0003, 1'b0);
    rd_expect("R2 rb ch7", 12'h084, 32'hA4A4_0004, 1'b0);
  endtask

  task automatic t_status_read;
    rd_expect("R3 ch0", 12'h000, cnt_of(0), 1'b0);
    rd_expect("R3 ch2", 12'h020, cnt_of(2), 1'b0);
    rd_expect("R3 ch4", 12'h050, cnt_of(4), 1'b0);
    rd_expect("R3 ch7", 12'h080, cnt_of(7), 1'b0);
  endtask

  task automatic t_status_load;
    bus(1'b1, 12'h010, 32'h0000_0055);
    chk("R4 disabled no load", ch_load, 8'h00);
    bus(1'b1, 12'h030, 32'h0000_0010);
    repeat (3) @(negedge clk);
    chk("R4 ch1 enabled", ch_enable, 8'h02);
    bus(1'b1, 12'h010, 32'h1234_5678);
    chk("R4 load strobe", ch_load, 8'h02);
    chk("R4 load value", ch_load_value, 32'h1234_5678);
    @(negedge clk);
    chk("R4 strobe one cycle", ch_load, 8'h00);
  endtask

  task automatic t_ctrl_order;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_offset = 12'h030; req_wdata = 32'h0000_0043;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 step1 enables", ch_enable, 8'h00);
    chk("R6 step1 settings", {ch_ext_clk, ch_ovf_irq}, 16'h0000);
    chk("R6 step1 busy", req_ready, 1'b0);
    @(negedge clk);
    chk("R6 step2 settings", {ch_ext_clk, ch_ovf_irq}, 16'h0102);
    chk("R6 step2 enables", ch_enable, 8'h00);
    chk("R6 step2 busy", req_ready, 1'b0);
    @(negedge clk);
    chk("R6 step3 enables", ch_enable, 8'h01);
    chk("R6 step3 ready", req_ready, 1'b1);
    rd_expect("R5 ctrl readback", 12'h030, 32'h0000_0043, 1'b0);
  endtask

  task automatic t_pulse;
    bus(1'b1, 12'h030, 32'h0000_004B);
    chk("R7 low pulse err", last_err, 1'b1);
    repeat (3) @(negedge clk);
    chk("R7 low pulse gated", ch_pulse, 8'h00);
    rd_expect("R7 low pulse stored", 12'h030, 32'h0000_004B, 1'b0);
    bus(1'b1, 12'h030, 32'h0080_004B);
    chk("R7 high pulse no err", last_err, 1'b0);
    repeat (3) @(negedge clk);
    chk("R7 ch5 pulse", ch_pulse, 8'h20);
    chk("R5 enables kept", ch_enable, 8'h01);
  endtask

  task automatic t_ctrl2;
    bus(1'b1, 12'h034, 32'hFFFF_FFFF);
    chk("R8 no err", last_err, 1'b0);
    @(negedge clk);
    chk("R8 outputs unchanged", {ch_enable, ch_ext_clk, ch_ovf_irq, ch_pulse}, 32'h0101_0220);
    rd_expect("R8 ctrl2 readback", 12'h034, 32'hFFFF_FFFF, 1'b0);
    rd_expect("R8 ctrl untouched", 12'h030, 32'h0080_004B, 1'b0);
  endtask

  task automatic t_illegal;
    rd_expect("R9 read 0x38", 12'h038, 32'h0, 1'b1);
    bus(1'b1, 12'h03C, 32'h0000_DEAD);
    chk("R9 write 0x3C err", last_err, 1'b1);
    @(negedge clk);
    chk("R9 err one cycle", err, 1'b0);
    rd_expect("R9 ctrl after bad write", 12'h030, 32'h0080_004B, 1'b0);
    rd_expect("R9 read 0x90", 12'h090, 32'h0, 1'b1);
    bus(1'b1, 12'h094, 32'h0000_BEEF);
    chk("R9 write 0x94 err", last_err, 1'b1);
    chk("R9 ch7 reload kept", ch_reload[7*DW +: DW], 32'hA4A4_0004);
    rd_expect("R9 read 0xFFC", 12'hFFC, 32'h0, 1'b1);
    bus(1'b1, 12'h014, 32'h0000_7777);
    chk("R10 write gives no rd_valid", last_rv, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) ch_count[i*DW +: DW] = cnt_of(i);
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_offset = '0; req_wdata = '0;
    last_err = 1'b0; last_rv = 1'b0; last_rd = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chan_map();
    t_status_read();
    t_status_load();
    t_ctrl_order();
    t_pulse();
    t_ctrl2();
    t_illegal();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R6 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule